// File: doc/BRIEF.md
# Disk Adapter Host Register Interface

This block is the processor-facing register front end of a disk adapter that serves up to four drives. It answers byte reads and writes at eight consecutive I/O port addresses starting at an 8-aligned base. Through these ports the host does four things. It reads a subsystem status byte. It loads the 16-bit memory address of a command parameter block and starts a command. It collects the result of the finished command. It resets the subsystem.

A separate command engine fetches the parameter block and carries out the command. It gets a one-cycle start pulse from this block, together with the latched parameter-block address. When the command finishes, it returns a done strobe, a 2-bit result type, an 8-bit error code and the command's 2-bit interrupt-control field. Completion sets an interrupt flip-flop. Reading the result type acknowledges that interrupt. Drive ready levels come from the attach logic and are sampled into the status register on every reset.

Top module: `disk_host_regs`

## Requirements
- R1: Only addresses whose upper five bits equal those of BASE_PORT (default 0x68) respond. A read at any other address returns 0x00, and a write there changes no register and produces no pulse.
- R2: A read at offset 0 returns the status byte. Bit 0 is drive 0 ready, bit 1 is drive 1 ready, bit 2 is the interrupt flip-flop, bit 3 is the PRESENT parameter, bit 4 is the ALT_PRESENT parameter, bit 5 is drive 2 ready, bit 6 is drive 3 ready, and bit 7 is 0. The ready bits hold the drive_ready values sampled at the last reset.
- R3: A write at offset 1 loads bits 7:0 of pblk_addr. A write at offset 2 loads bits 15:8 and raises cmd_start for exactly one cycle, in the cycle after the write.
- R4: Between a start and the next done strobe, the block is busy. A write at offset 2 while busy is ignored: pblk_addr is unchanged and no cmd_start is issued. A done strobe ends busy.
- R5: A done strobe sets the interrupt flip-flop, so status bit 2 reads 1. It also captures the result type and the error code.
- R6: A read at offset 1 returns the result type in bits 1:0, with bits 7:2 zero. The read clears the interrupt flip-flop.
- R7: A read at offset 3 returns the result byte. When the result type is 2'b10, the byte holds drive 0 ready in bit 6 and drive 1 ready in bit 7, with the other bits zero. For every other result type it returns the captured error code.
- R8: irq equals the interrupt flip-flop when the interrupt-control field captured at the last done was 2'b00. For any other value, irq stays 0.
- R9: A write at offset 7 has these effects: the error code becomes 0x00, the result type becomes 2'b00, and the interrupt flip-flop and busy are cleared. It also resamples drive_ready into the status register. soft_rst pulses for one cycle in the cycle after the write.
- R10: After rst_n, the status byte holds the presence parameters and the sampled ready bits. The result type is 0, the error code is 0, and pblk_addr, cmd_start, soft_rst and irq are 0.
- R11: When a done strobe and a result-type read fall in the same cycle, the interrupt flip-flop ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 8 | I/O port address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle io_rd is high |
| drive_ready | input | 4 | Ready level of drives 3..0 |
| done | input | 1 | Command completion strobe |
| done_type | input | 2 | Result type of the completed command |
| done_code | input | 8 | Error code of the completed command |
| done_ictl | input | 2 | Interrupt-control field of the completed command |
| pblk_addr | output | 16 | Latched parameter-block address |
| cmd_start | output | 1 | One-cycle start pulse to the command engine |
| soft_rst | output | 1 | One-cycle subsystem reset pulse |
| irq | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a done strobe that lands in the same cycle as the acknowledging result-type read. The bench drives both strobes from one task inside a single clock cycle, then checks that irq and status bit 2 stay set. The second is the busy window. A second start write is issued before the done strobe, and then again right after a subsystem reset that arrived while busy, to show that the reset releases the block. The ready-latching rule is reached by changing drive_ready after reset and reading status before and after an offset-7 write.

// File: rtl/disk_host_regs.sv
module disk_host_regs #(
  parameter logic [7:0] BASE_PORT   = 8'h68,
  parameter logic       PRESENT     = 1'b1,
  parameter logic       ALT_PRESENT = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  io_addr,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [3:0]  drive_ready,
  input  logic        done,
  input  logic [1:0]  done_type,
  input  logic [7:0]  done_code,
  input  logic [1:0]  done_ictl,
  output logic [15:0] pblk_addr,
  output logic        cmd_start,
  output logic        soft_rst,
  output logic        irq
);

  logic       hit;
  logic [2:0] off;
  logic       wr_lo, wr_hi, wr_rst, rd_type;
  logic [3:0] rdy_q;
  logic       int_ff, int_en, busy;
  logic [1:0] rtype;
  logic [7:0] rcode;
  logic [7:0] status, rbyte;

  assign hit     = (io_addr[7:3] == BASE_PORT[7:3]);
  assign off     = io_addr[2:0];
  assign wr_lo   = io_wr & hit & (off == 3'd1);
  assign wr_hi   = io_wr & hit & (off == 3'd2) & ~busy;
  assign wr_rst  = io_wr & hit & (off == 3'd7);
  assign rd_type = io_rd & hit & (off == 3'd1);

  assign status = {1'b0, rdy_q[3], rdy_q[2], ALT_PRESENT, PRESENT, int_ff, rdy_q[1], rdy_q[0]};
  assign rbyte  = (rtype == 2'b10) ? {rdy_q[1], rdy_q[0], 6'b0} : rcode;
  assign irq    = int_ff & int_en;

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd && hit) begin
      case (off)
        3'd0:    io_rdata = status;
        3'd1:    io_rdata = {6'b0, rtype};
        3'd3:    io_rdata = rbyte;
        default: io_rdata = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q     <= drive_ready;
      int_ff    <= 1'b0;
      int_en    <= 1'b0;
      busy      <= 1'b0;
      rtype     <= 2'b00;
      rcode     <= 8'h00;
      pblk_addr <= 16'h0000;
      cmd_start <= 1'b0;
      soft_rst  <= 1'b0;
    end else begin
      cmd_start <= wr_hi;
      soft_rst  <= wr_rst;
      if (wr_lo) pblk_addr[7:0]  <= io_wdata;
      if (wr_hi) pblk_addr[15:8] <= io_wdata;
      if (wr_rst) begin
        rdy_q  <= drive_ready;
        rcode  <= 8'h00;
        rtype  <= 2'b00;
        int_ff <= 1'b0;
        int_en <= 1'b0;
        busy   <= 1'b0;
      end else begin
        if (done) begin
          busy   <= 1'b0;
          int_ff <= 1'b1;
          int_en <= (done_ictl == 2'b00);
          rtype  <= done_type;
          rcode  <= done_code;
        end else if (rd_type) begin
          int_ff <= 1'b0;
        end
        if (wr_hi) busy <= 1'b1;
      end
    end
  end

endmodule

module disk_host_regs_chk #(
  parameter logic [7:0] BASE_PORT = 8'h68
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] io_addr,
  input logic       io_rd,
  input logic       io_wr,
  input logic       busy,
  input logic       done,
  input logic       int_ff,
  input logic [1:0] rtype,
  input logic [7:0] rcode,
  input logic       cmd_start,
  input logic       soft_rst,
  input logic       irq
);
  logic hit;
  assign hit = (io_addr[7:3] == BASE_PORT[7:3]);

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);

  assert_start_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit && io_addr[2:0] == 3'd2 && !busy) |=> cmd_start);

  assert_busy_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit && io_addr[2:0] == 3'd2 && busy) |=> !cmd_start);

  assert_done_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(io_wr && hit && io_addr[2:0] == 3'd7)) |=> int_ff);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && hit && io_addr[2:0] == 3'd1 && !done && !(io_wr && hit && io_addr[2:0] == 3'd7)) |=> !int_ff);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> int_ff);

  assert_softreset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit && io_addr[2:0] == 3'd7) |=> (soft_rst && !int_ff && rtype == 2'b00 && rcode == 8'h00));
endmodule

bind disk_host_regs disk_host_regs_chk #(.BASE_PORT(BASE_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .busy(busy), .done(done), .int_ff(int_ff), .rtype(rtype), .rcode(rcode),
  .cmd_start(cmd_start), .soft_rst(soft_rst), .irq(irq)
);

// File: tb/disk_host_regs_bench.sv
module disk_host_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_addr = 8'h00;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic [3:0]  drive_ready = 4'b0101;
  logic        done = 1'b0;
  logic [1:0]  done_type = 2'b00, done_ictl = 2'b00;
  logic [7:0]  done_code = 8'h00;
  logic [15:0] pblk_addr;
  logic        cmd_start, soft_rst, irq;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  disk_host_regs u_disk_host_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .drive_ready(drive_ready),
    .done(done), .done_type(done_type), .done_code(done_code), .done_ictl(done_ictl),
    .pblk_addr(pblk_addr), .cmd_start(cmd_start), .soft_rst(soft_rst), .irq(irq)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (io_rd && exp_q.size() > 0) chk(io_rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag, input bit with_done = 0);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    io_addr = a; io_rd = 1'b1;
    if (with_done) done = 1'b1;
    @(posedge clk); #1;
    io_rd = 1'b0; done = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic fin(input logic [1:0] t, input logic [7:0] c, input logic [1:0] ic);
    @(posedge clk); #1;
    done_type = t; done_code = c; done_ictl = ic; done = 1'b1;
    @(posedge clk); #1;
    done = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(pblk_addr, 16'h0000, "R10 addr");
    chk(cmd_start, 0, "R10 start");
    chk(soft_rst, 0, "R10 softrst");
    chk(irq, 0, "R10 irq");
    rd(8'h68, 8'h29, "R10 R2 status");
    rd(8'h6B, 8'h00, "R10 result byte");
    rd(8'h69, 8'h00, "R10 result type");
    rd(8'h60, 8'h00, "R1 foreign read");
    wr(8'h61, 8'h55);
    chk(pblk_addr, 16'h0000, "R1 foreign write");
    chk(cmd_start, 0, "R1 no start");
    wr(8'h69, 8'h34);
    wr(8'h6A, 8'h12);
    chk(cmd_start, 1, "R3 start pulse");
    chk(pblk_addr, 16'h1234, "R3 address");
    @(posedge clk); #1;
    chk(cmd_start, 0, "R3 single cycle");
    wr(8'h6A, 8'h99);
    chk(cmd_start, 0, "R4 busy start");
    chk(pblk_addr, 16'h1234, "R4 busy address");
    fin(2'b00, 8'h08, 2'b00);
    chk(irq, 1, "R8 irq enabled");
    rd(8'h68, 8'h2D, "R5 status int bit");
    wr(8'h77, 8'h00);
    chk(irq, 1, "R1 foreign reset");
    rd(8'h6B, 8'h08, "R7 error code");
    rd(8'h69, 8'h00, "R6 type read");
    chk(irq, 0, "R6 ack clears");
    rd(8'h68, 8'h29, "R6 status cleared");
    wr(8'h6A, 8'h20);
    chk(cmd_start, 1, "R4 idle after done");
    fin(2'b10, 8'h80, 2'b01);
    chk(irq, 0, "R8 irq masked");
    rd(8'h68, 8'h2D, "R5 status masked");
    rd(8'h6B, 8'h40, "R7 ready byte");
    rd(8'h69, 8'h02, "R6 type 10");
    fin(2'b11, 8'h20, 2'b00);
    rd(8'h6B, 8'h20, "R7 type 11 code");
    rd(8'h69, 8'h03, "R6 type 11");
    done_type = 2'b00; done_code = 8'h04; done_ictl = 2'b00;
    rd(8'h69, 8'h03, "R11 type read", 1);
    chk(irq, 1, "R11 done wins");
    rd(8'h68, 8'h2D, "R11 status");
    rd(8'h6B, 8'h04, "R11 code");
    drive_ready = 4'b1011;
    rd(8'h68, 8'h2D, "R2 ready latched");
    wr(8'h6A, 8'h40);
    chk(cmd_start, 1, "R4 start before reset");
    wr(8'h6F, 8'h00);
    chk(soft_rst, 1, "R9 pulse");
    chk(irq, 0, "R9 irq");
    rd(8'h68, 8'h4B, "R9 status rebuilt");
    chk(soft_rst, 0, "R9 single cycle");
    rd(8'h6B, 8'h00, "R9 code cleared");
    rd(8'h69, 8'h00, "R9 type cleared");
    wr(8'h6A, 8'h77);
    chk(cmd_start, 1, "R9 busy cleared");
    chk(pblk_addr, 16'h7734, "R9 address");
    fin(2'b10, 8'h00, 2'b00);
    rd(8'h6B, 8'hC0, "R7 ready byte new");
    repeat (2) @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule